// File: doc/BRIEF.md
# Dithered Complex Numerically Controlled Oscillator

This block produces one complex phasor sample (a cosine and a sine) on every enabled clock. The phasor is meant to feed the mixer of a digital upconverter. A wide phase accumulator advances by a programmable step. The step sets the carrier frequency to within about 1 Hz at a 122.88 MHz sample clock: the accumulator is 28 bits wide, and a 32 MHz carrier at that rate needs a step of 69905067.

Only the top 12 phase bits address the waveform lookup. To break up the periodic truncation error, a pseudo-random value is added to the 16 discarded bits just before truncation. That value comes from a small on-chip linear feedback shift register. The accumulator itself never carries the dither. The lookup holds only a quarter of a sine period. The quadrant is taken from the two top phase bits, and the cosine is read from the same table at a quarter-period phase offset.

Top module: `nco_dither`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator, loads the dither register with the seed 0xACE1, and on the next edge shows `valid_o` = 0 and both outputs equal to zero.
- R2: On each enabled cycle the 28-bit accumulator adds `phase_inc` as an unsigned value and wraps modulo 2^28.
- R3: While `en` is low, the accumulator and the dither register keep their values. `valid_o` goes low two cycles later and the outputs keep their last values.
- R4: The dither is a 16-bit shift register that advances once per enabled cycle. It shifts left and inserts the XOR of bits 15, 13, 12 and 10 at bit 0. The lookup phase is bits 27..16 of (accumulator + dither) mod 2^28, and it is taken before the accumulator update of that cycle.
- R5: For lookup phase p, `sin_o` equals round(32767 * sin(2*pi*(p + 0.5)/4096)) within 1 LSB, as a signed 16-bit value with 15 fractional bits. The value never reaches -32768.
- R6: `cos_o` equals round(32767 * cos(2*pi*(p + 0.5)/4096)) within 1 LSB for the same phase p as `sin_o`.
- R7: The sample whose phase is taken at an enabled edge appears two edges later, and `valid_o` is high in exactly those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the oscillator and issue one sample |
| phase_inc | input | 28 | Unsigned phase step per enabled cycle |
| valid_o | output | 1 | Marks the cycles that carry a new sample |
| sin_o | output | 16 | Signed sine sample, 15 fractional bits |
| cos_o | output | 16 | Signed cosine sample, 15 fractional bits |

## Verification
The step used for the 32 MHz carrier exercises all four quadrants with a non-trivial fractional phase, so an error in the quadrant fold or in the dither addition shows up as a large sample error. A zero step leaves only the dither. It separates a dither that lands on the discarded bits from one that is misplaced or never advances. A half-period step and an all-ones step check the modulo wrap in both directions. A step of exactly one lookup position distinguishes a truncation point that is off by one bit. Alternating and long low stretches of `en`, together with a reset in mid-run, show the hold behaviour, the two-cycle valid alignment and the restart from the seed.

// File: rtl/nco_dither.sv
module nco_dither #(
  parameter int ACC_W = 28,
  parameter int Q_W = 12,
  parameter int OUT_W = 16,
  parameter int unsigned SEED = 'hACE1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        phase_inc,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int DW = ACC_W - Q_W;
  localparam int AW = Q_W - 2;
  localparam int QN = 1 << AW;
  localparam int MW = OUT_W - 1;

  function automatic logic [MW-1:0] quarter_sine(input int k);
    real x, term, sum;
    x = (3.14159265358979323846 / 2.0) * (real'(k) + 0.5) / real'(QN);
    term = x;
    sum = x;
    for (int n = 1; n < 8; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      sum = sum + term;
    end
    return MW'($rtoi(sum * real'((1 << MW) - 1) + 0.5));
  endfunction

  logic [MW-1:0] rom [QN];
  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign rom[k] = quarter_sine(k);
  end

  logic [ACC_W-1:0] acc_q;
  logic [DW-1:0]    lfsr_q;
  logic [Q_W-1:0]   ph_q;
  logic             v1_q;

  logic [ACC_W-1:0] dithered;
  logic             lfsr_fb;
  logic [Q_W-1:0]   cph;
  logic [AW-1:0]    s_addr, c_addr;
  logic [MW-1:0]    s_mag, c_mag;
  logic signed [OUT_W-1:0] s_val, c_val;

  assign dithered = acc_q + {{Q_W{1'b0}}, lfsr_q};
  assign lfsr_fb  = lfsr_q[DW-1] ^ lfsr_q[DW-3] ^ lfsr_q[DW-4] ^ lfsr_q[DW-6];
  assign cph      = ph_q + Q_W'(QN);

  assign s_addr = ph_q[AW] ? ~ph_q[AW-1:0] : ph_q[AW-1:0];
  assign c_addr = cph[AW]  ? ~cph[AW-1:0]  : cph[AW-1:0];
  assign s_mag  = rom[s_addr];
  assign c_mag  = rom[c_addr];
  assign s_val  = ph_q[Q_W-1] ? -$signed({1'b0, s_mag}) : $signed({1'b0, s_mag});
  assign c_val  = cph[Q_W-1]  ? -$signed({1'b0, c_mag}) : $signed({1'b0, c_mag});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      lfsr_q  <= DW'(SEED);
      ph_q    <= '0;
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else begin
      v1_q    <= en;
      valid_o <= v1_q;
      sin_o   <= s_val;
      cos_o   <= c_val;
      if (en) begin
        acc_q  <= acc_q + phase_inc;
        lfsr_q <= {lfsr_q[DW-2:0], lfsr_fb};
        ph_q   <= Q_W'(dithered >> DW);
      end
    end
  end
endmodule

// File: rtl/nco_dither_chk.sv
module nco_dither_chk #(
  parameter int ACC_W = 28,
  parameter int DW = 16,
  parameter int OUT_W = 16,
  parameter int unsigned SEED = 'hACE1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        phase_inc,
  input logic [ACC_W-1:0]        acc,
  input logic [DW-1:0]           lfsr,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] sin_o,
  input logic signed [OUT_W-1:0] cos_o
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && lfsr == DW'(SEED) && !valid_o && sin_o == '0 && cos_o == '0));

  p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> acc == $past(acc) + $past(phase_inc));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc) && $stable(lfsr)));

  p_lfsr_alive_r4: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  p_no_min_r5: assert property (@(posedge clk) disable iff (rst)
    sin_o != {1'b1, {(OUT_W-1){1'b0}}});

  p_no_min_r6: assert property (@(posedge clk) disable iff (rst)
    cos_o != {1'b1, {(OUT_W-1){1'b0}}});

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) |-> valid_o == $past(en, 2));
endmodule

bind nco_dither nco_dither_chk #(
  .ACC_W(ACC_W), .DW(ACC_W - Q_W), .OUT_W(OUT_W), .SEED(SEED)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .phase_inc(phase_inc),
  .acc(acc_q), .lfsr(lfsr_q), .valid_o(valid_o),
  .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/nco_dither_tb_top.sv
module nco_dither_tb_top;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [27:0] phase_inc = '0;
  logic valid_o;
  logic signed [15:0] sin_o, cos_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nco_dither dut_i (
    .clk(clk), .rst(rst), .en(en), .phase_inc(phase_inc),
    .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic int rnd(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int ref_sin(int p);
    return rnd(32767.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0));
  endfunction

  function automatic int ref_cos(int p);
    return rnd(32767.0 * $cos(2.0 * PI * (real'(p) + 0.5) / 4096.0));
  endfunction

  // Behavioural reference
  longint m_acc;
  int m_lf, m_ph, m_v1, m_ev, m_es, m_ec;
  bit m_en_prev;

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      m_acc = 0; m_lf = 'hACE1; m_ph = 0; m_v1 = 0;
      m_ev = 0; m_es = 0; m_ec = 0;
    end else begin
      m_ev = m_v1;
      m_es = ref_sin(m_ph);
      m_ec = ref_cos(m_ph);
      m_v1 = en;
      if (en) begin
        m_ph = int'(((m_acc + longint'(m_lf)) % (64'd1 << 28)) / 65536);
        m_acc = (m_acc + longint'(phase_inc)) % (64'd1 << 28);
        m_lf = ((m_lf << 1) & 'hFFFF) |
               (((m_lf >> 15) ^ (m_lf >> 13) ^ (m_lf >> 12) ^ (m_lf >> 10)) & 1);
      end
    end
    m_en_prev = en;
  end

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(valid_o) != m_ev) begin
        fails++;
        $display("FAIL R7/R3 valid_o actual=%0d expected=%0d t=%0t", valid_o, m_ev, $time);
      end
      if (absdiff(int'(sin_o), m_es) > 1) begin
        fails++;
        $display("FAIL R5 (phase path R2 R4) sin_o actual=%0d expected=%0d t=%0t",
                 sin_o, m_es, $time);
      end
      if (absdiff(int'(cos_o), m_ec) > 1) begin
        fails++;
        $display("FAIL R6 (phase path R2 R4) cos_o actual=%0d expected=%0d t=%0t",
                 cos_o, m_ec, $time);
      end
    end
  end

  task automatic step(input logic [27:0] inc, input logic e, input int n);
    for (int i = 0; i < n; i++) begin
      phase_inc = inc;
      en = e;
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state();
    checks++;
    if (valid_o !== 1'b0 || sin_o !== 16'sd0 || cos_o !== 16'sd0) begin
      fails++;
      $display("FAIL R1 reset state actual v=%0d s=%0d c=%0d expected 0 0 0",
               valid_o, sin_o, cos_o);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1; en = 0; phase_inc = '0;
    repeat (4) @(negedge clk);
    check_reset_state();
    rst = 0;
    step(28'd69905067, 1'b1, 400);   // R2 R4 R5 R6 R7 carrier
    for (int i = 0; i < 200; i++) step(28'd69905067, 1'(i % 2), 1); // R3 R7
    step(28'd69905067, 1'b0, 20);    // R3 long hold
    step(28'd0, 1'b1, 100);          // R4 dither alone
    step(28'h8000000, 1'b1, 100);    // R2 half-period wrap
    step(28'hFFFFFFF, 1'b1, 100);    // R2 backward wrap
    step(28'h0010000, 1'b1, 100);    // R4 truncation point
    rst = 1;
    step(28'd12345678, 1'b1, 3);
    check_reset_state();             // R1 mid-run
    rst = 0;
    step(28'd12345678, 1'b1, 60);
    step(28'd12345678, 1'b0, 4);
    finish_run();
  end

  initial begin
    wait (cycles > 200000);
    fails++;
    $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
    finish_run();
  end
endmodule